// File: doc/BRIEF.md
# Eight-Port Omega Switching Network

This block moves data words from a set of source ports to a set of destination ports through a multistage network of 2x2 switches. The default size is eight ports. Each source offers one request per cycle: a valid bit, a destination index and a data word. The network has log2(N) stages. Within each stage, a switch sees two adjacent links and steers each message up or down using one bit of its destination, starting with the most significant bit. Between one stage and the next, the links are permuted by a perfect shuffle, which rotates the link index left by one bit. After the last stage, a message sits on the output link whose index equals its destination.

The network blocks internally. Two requests with distinct destinations can still need the same switch output, and some permutations that a full crossbar would carry are then refused. When two messages clash inside a switch, the one on the lower-numbered link passes and the other is dropped. In the same cycle, each source learns whether its request was granted or blocked. The block keeps no request state, so a blocked source keeps its request up and competes again on the next cycle. Granted messages are registered at the network's edge. Each appears on its destination port one clock later, tagged with the index of the source that sent it.

Top module: `omega_net`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every delivery valid bit is 0. With no request valid, no grant is given.
- R2: A lone valid request, from any source to any destination, is always granted. One cycle later it appears on destination port `dst` with `dlv_src` equal to the source index and `dlv_data` equal to the word sent.
- R3: In every cycle, each valid source is either granted or blocked, never both. An idle source is neither. Grant and block are combinational functions of the same cycle's inputs.
- R4: Routing follows a fixed structure. Stage k (k = 0 first) pairs links 2j and 2j+1 in one switch. That switch sends a message to output 2j when destination bit (log2(N)-1-k) is 0, and to output 2j+1 when that bit is 1. Output link q of every stage except the last feeds link ((q<<1)|(q>>(log2(N)-1))) mod N of the next stage.
- R5: When both inputs of a switch want the same output, the message on the even (upper) input wins and the odd input's message is blocked. In stage 0 this means source 2j beats source 2j+1 whenever their destinations share the most significant bit.
- R6: Source 0 to destination 5 and source 1 to destination 7 cannot both pass in one cycle. Source 0 is granted and source 1 is blocked, although the destinations differ.
- R7: Every request granted in a cycle is delivered on the next cycle, on its destination port. No port is valid without a matching grant from the previous cycle.
- R8: When several sources target one destination, exactly one of them is granted.
- R9: The outcome depends only on the current cycle's inputs. A blocked request that is held unchanged gets the same result each cycle, and it is granted in the first cycle after the competing request is withdrawn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | NUM_PORTS | Per-source request valid |
| req_dst | input | NUM_PORTS*log2(NUM_PORTS) | Per-source destination index |
| req_data | input | NUM_PORTS*DATA_W | Per-source data word |
| req_grant | output | NUM_PORTS | Request passed all stages this cycle |
| req_block | output | NUM_PORTS | Request lost a switch conflict this cycle |
| dlv_vld | output | NUM_PORTS | Per-destination delivery valid, registered |
| dlv_src | output | NUM_PORTS*log2(NUM_PORTS) | Index of the source being delivered |
| dlv_data | output | NUM_PORTS*DATA_W | Delivered data word |

## Verification
A sweep over all 64 single source-to-destination pairs confirms that every path through the shuffle wiring reaches the right port. These cases have no contention, so a fault here is a routing or wiring fault. Next come structured permutations: identity, cyclic shifts, bit reversal and the 0-to-5 / 1-to-7 pair. These tell apart permutations the network carries from those it refuses, and they check that the even input wins each clash. All-to-one patterns exercise many-to-one arbitration. A hold-then-withdraw sequence shows the block keeps no memory between cycles. A long run of pseudo-random partial loads is then compared, source by source, against a stage-by-stage arithmetic model.

// File: rtl/omega_pkg.sv
package omega_pkg;
   // Perfect shuffle of a link index: rotate the index left by one bit.
   function automatic int shuffle_pos(input int pos, input int bits);
      int msb;
      msb = (pos >> (bits - 1)) & 1;
      return ((pos << 1) & ((1 << bits) - 1)) | msb;
   endfunction
endpackage

// File: rtl/omega_sw2.sv
module omega_sw2 #(
   parameter int AW         = 3,
   parameter int PW         = 19,
   parameter int SEL_BIT    = 2,
   parameter bit UPPER_WINS = 1'b1
) (
   input  logic [1:0]                 in_v,
   input  logic [1:0][AW-1:0]         in_dst,
   input  logic [1:0][PW-1:0]         in_pay,
   output logic [1:0]                 out_v,
   output logic [1:0][AW-1:0]         out_dst,
   output logic [1:0][PW-1:0]         out_pay
);
   logic [1:0] want;
   logic       clash;
   logic [1:0] pass;

   assign want[0] = in_dst[0][SEL_BIT];
   assign want[1] = in_dst[1][SEL_BIT];
   assign clash   = in_v[0] & in_v[1] & (want[0] == want[1]);

   generate
      if (UPPER_WINS) begin : g_upper
         assign pass = {in_v[1] & ~clash, in_v[0]};
      end else begin : g_lower
         assign pass = {in_v[1], in_v[0] & ~clash};
      end
   endgenerate

   always_comb begin
      for (int k = 0; k < 2; k++) begin
         out_v[k]   = 1'b0;
         out_dst[k] = '0;
         out_pay[k] = '0;
         if (pass[0] && want[0] == 1'(k)) begin
            out_v[k]   = 1'b1;
            out_dst[k] = in_dst[0];
            out_pay[k] = in_pay[0];
         end else if (pass[1] && want[1] == 1'(k)) begin
            out_v[k]   = 1'b1;
            out_dst[k] = in_dst[1];
            out_pay[k] = in_pay[1];
         end
      end
   end
endmodule

// File: rtl/omega_stage.sv
module omega_stage #(
   parameter int NUM_PORTS  = 8,
   parameter int AW         = 3,
   parameter int PW         = 19,
   parameter int SEL_BIT    = 2,
   parameter bit SHUFFLE    = 1'b1,
   parameter bit UPPER_WINS = 1'b1
) (
   input  logic [NUM_PORTS-1:0]          in_v,
   input  logic [NUM_PORTS-1:0][AW-1:0]  in_dst,
   input  logic [NUM_PORTS-1:0][PW-1:0]  in_pay,
   output logic [NUM_PORTS-1:0]          out_v,
   output logic [NUM_PORTS-1:0][AW-1:0]  out_dst,
   output logic [NUM_PORTS-1:0][PW-1:0]  out_pay
);
   localparam int NSW = NUM_PORTS / 2;

   logic [NUM_PORTS-1:0]         sw_v;
   logic [NUM_PORTS-1:0][AW-1:0] sw_dst;
   logic [NUM_PORTS-1:0][PW-1:0] sw_pay;

   for (genvar j = 0; j < NSW; j++) begin : g_sw
      omega_sw2 #(
         .AW(AW), .PW(PW), .SEL_BIT(SEL_BIT), .UPPER_WINS(UPPER_WINS)
      ) u_sw (
         .in_v   (in_v[2*j+1 -: 2]),
         .in_dst (in_dst[2*j+1 -: 2]),
         .in_pay (in_pay[2*j+1 -: 2]),
         .out_v  (sw_v[2*j+1 -: 2]),
         .out_dst(sw_dst[2*j+1 -: 2]),
         .out_pay(sw_pay[2*j+1 -: 2])
      );
   end

   for (genvar q = 0; q < NUM_PORTS; q++) begin : g_wire
      if (SHUFFLE) begin : g_shuf
         localparam int DP = omega_pkg::shuffle_pos(q, AW);
         assign out_v[DP]   = sw_v[q];
         assign out_dst[DP] = sw_dst[q];
         assign out_pay[DP] = sw_pay[q];
      end else begin : g_straight
         assign out_v[q]   = sw_v[q];
         assign out_dst[q] = sw_dst[q];
         assign out_pay[q] = sw_pay[q];
      end
   end
endmodule

// File: rtl/omega_net.sv
module omega_net #(
   parameter int NUM_PORTS  = 8,
   parameter int DATA_W     = 16,
   parameter bit UPPER_WINS = 1'b1,
   localparam int AW        = $clog2(NUM_PORTS)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NUM_PORTS-1:0]              req_vld,
   input  logic [NUM_PORTS-1:0][AW-1:0]      req_dst,
   input  logic [NUM_PORTS-1:0][DATA_W-1:0]  req_data,
   output logic [NUM_PORTS-1:0]              req_grant,
   output logic [NUM_PORTS-1:0]              req_block,
   output logic [NUM_PORTS-1:0]              dlv_vld,
   output logic [NUM_PORTS-1:0][AW-1:0]      dlv_src,
   output logic [NUM_PORTS-1:0][DATA_W-1:0]  dlv_data
);
   localparam int PW     = AW + DATA_W;
   localparam int STAGES = AW;

   initial begin
      assert (NUM_PORTS >= 2 && (NUM_PORTS & (NUM_PORTS - 1)) == 0)
         else $error("omega_net: NUM_PORTS must be a power of two, at least 2");
      assert (DATA_W >= 1)
         else $error("omega_net: DATA_W must be positive");
   end

   logic [NUM_PORTS-1:0]         lk_v   [STAGES+1];
   logic [NUM_PORTS-1:0][AW-1:0] lk_dst [STAGES+1];
   logic [NUM_PORTS-1:0][PW-1:0] lk_pay [STAGES+1];

   assign lk_v[0]   = req_vld;
   assign lk_dst[0] = req_dst;
   for (genvar s = 0; s < NUM_PORTS; s++) begin : g_tag
      assign lk_pay[0][s] = {AW'(s), req_data[s]};
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      omega_stage #(
         .NUM_PORTS (NUM_PORTS),
         .AW        (AW),
         .PW        (PW),
         .SEL_BIT   (AW - 1 - g),
         .SHUFFLE   (g < STAGES - 1),
         .UPPER_WINS(UPPER_WINS)
      ) u_stage (
         .in_v   (lk_v[g]),
         .in_dst (lk_dst[g]),
         .in_pay (lk_pay[g]),
         .out_v  (lk_v[g+1]),
         .out_dst(lk_dst[g+1]),
         .out_pay(lk_pay[g+1])
      );
   end

   // Map surviving messages back to the source that sent them.
   always_comb begin
      req_grant = '0;
      for (int s = 0; s < NUM_PORTS; s++) begin
         for (int d = 0; d < NUM_PORTS; d++) begin
            if (lk_v[STAGES][d] && lk_pay[STAGES][d][PW-1:DATA_W] == AW'(s))
               req_grant[s] = 1'b1;
         end
      end
   end
   assign req_block = req_vld & ~req_grant;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dlv_vld  <= '0;
         dlv_src  <= '0;
         dlv_data <= '0;
      end else begin
         for (int d = 0; d < NUM_PORTS; d++) begin
            dlv_vld[d]  <= lk_v[STAGES][d] && (lk_dst[STAGES][d] == AW'(d));
            dlv_src[d]  <= lk_pay[STAGES][d][PW-1:DATA_W];
            dlv_data[d] <= lk_pay[STAGES][d][DATA_W-1:0];
         end
      end
   end
endmodule

// File: rtl/omega_net_chk.sv
module omega_net_chk #(
   parameter int NUM_PORTS  = 8,
   parameter int DATA_W     = 16,
   parameter bit UPPER_WINS = 1'b1,
   localparam int AW        = $clog2(NUM_PORTS)
) (
   input logic                              clk,
   input logic                              rst_n,
   input logic [NUM_PORTS-1:0]              req_vld,
   input logic [NUM_PORTS-1:0][AW-1:0]      req_dst,
   input logic [NUM_PORTS-1:0][DATA_W-1:0]  req_data,
   input logic [NUM_PORTS-1:0]              req_grant,
   input logic [NUM_PORTS-1:0]              req_block,
   input logic [NUM_PORTS-1:0]              dlv_vld,
   input logic [NUM_PORTS-1:0][AW-1:0]      dlv_src,
   input logic [NUM_PORTS-1:0][DATA_W-1:0]  dlv_data
);
   logic [NUM_PORTS-1:0]              p_grant;
   logic [NUM_PORTS-1:0][AW-1:0]      p_dst;
   logic [NUM_PORTS-1:0][DATA_W-1:0]  p_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_grant <= '0;
         p_dst   <= '0;
         p_data  <= '0;
      end else begin
         p_grant <= req_grant;
         p_dst   <= req_dst;
         p_data  <= req_data;
      end
   end

   // R3: a valid source is granted or blocked, never both; an idle one is neither
   a_r3_excl: assert property (@(posedge clk) disable iff (!rst_n)
      ((req_grant & req_block) == '0) && ((req_grant | req_block) == req_vld));

   // R2: a lone request is never blocked
   a_r2_single: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(req_vld) == 1) |-> (req_grant == req_vld));

   // R7: deliveries match last cycle's grants in number
   a_r7_count: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(dlv_vld) == $countones(p_grant));

   for (genvar s = 0; s < NUM_PORTS; s++) begin : g_src
      // R7: each grant lands on its destination with its tag and word
      a_r7_deliver: assert property (@(posedge clk) disable iff (!rst_n)
         p_grant[s] |-> (dlv_vld[p_dst[s]] && dlv_src[p_dst[s]] == AW'(s)
                         && dlv_data[p_dst[s]] == p_data[s]));
   end

   if (UPPER_WINS) begin : g_prio
      for (genvar j = 0; j < NUM_PORTS / 2; j++) begin : g_pair
         // R5: in stage 0 the even source beats its odd neighbour
         a_r5_stage0_prio: assert property (@(posedge clk) disable iff (!rst_n)
            (req_vld[2*j] && req_vld[2*j+1]
             && req_dst[2*j][AW-1] == req_dst[2*j+1][AW-1]) |-> req_block[2*j+1]);
      end
   end
endmodule

bind omega_net omega_net_chk #(
   .NUM_PORTS (NUM_PORTS),
   .DATA_W    (DATA_W),
   .UPPER_WINS(UPPER_WINS)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_vld  (req_vld),
   .req_dst  (req_dst),
   .req_data (req_data),
   .req_grant(req_grant),
   .req_block(req_block),
   .dlv_vld  (dlv_vld),
   .dlv_src  (dlv_src),
   .dlv_data (dlv_data)
);

// File: tb/sim_omega_net.sv
module sim_omega_net;
   localparam int N  = 8;
   localparam int AW = 3;
   localparam int DW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [N-1:0]          req_vld;
   logic [N-1:0][AW-1:0]  req_dst;
   logic [N-1:0][DW-1:0]  req_data;
   logic [N-1:0]          req_grant, req_block, dlv_vld;
   logic [N-1:0][AW-1:0]  dlv_src;
   logic [N-1:0][DW-1:0]  dlv_data;

   int n_chk = 0;
   int n_fail = 0;
   int vec_no = 0;
   bit done = 1'b0;
   logic [31:0] rng = 32'h1234_5679;

   omega_net #(.NUM_PORTS(N), .DATA_W(DW), .UPPER_WINS(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_dst(req_dst),
      .req_data(req_data), .req_grant(req_grant), .req_block(req_block),
      .dlv_vld(dlv_vld), .dlv_src(dlv_src), .dlv_data(dlv_data));

   task automatic check(input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h (vector %0d)",
                  tag, what, act, exp, vec_no);
      end
   endtask

   // Stage-by-stage arithmetic model: even input wins a clash.
   task automatic model(output logic [N-1:0] g);
      int pos [N];
      bit alive [N];
      bit keep [N];
      for (int s = 0; s < N; s++) begin
         pos[s] = s;
         alive[s] = req_vld[s];
      end
      for (int st = 0; st < AW; st++) begin
         int bp = AW - 1 - st;
         for (int s = 0; s < N; s++) begin
            keep[s] = alive[s];
            if (alive[s] && (pos[s] % 2) == 1) begin
               for (int t = 0; t < N; t++) begin
                  if (t != s && alive[t] && pos[t] == pos[s] - 1
                      && req_dst[t][bp] == req_dst[s][bp])
                     keep[s] = 1'b0;
               end
            end
         end
         for (int s = 0; s < N; s++) begin
            alive[s] = keep[s];
            if (alive[s]) begin
               int p = (pos[s] & ~1) | int'(req_dst[s][bp]);
               if (st < AW - 1) p = ((p << 1) | (p >> (AW - 1))) & (N - 1);
               pos[s] = p;
            end
         end
      end
      for (int s = 0; s < N; s++) g[s] = alive[s];
   endtask

   // Inputs are already set (at a falling edge); check grants now and delivery next cycle.
   task automatic run_vec(input string tag);
      logic [N-1:0] g;
      logic [N-1:0] ev;
      logic [N-1:0][AW-1:0] es;
      logic [N-1:0][DW-1:0] ed;
      #1;
      model(g);
      ev = '0; es = '0; ed = '0;
      for (int s = 0; s < N; s++) begin
         check(tag, $sformatf("grant[%0d]", s), 64'(req_grant[s]), 64'(g[s]));
         check(tag, $sformatf("block[%0d]", s), 64'(req_block[s]), 64'(req_vld[s] & ~g[s]));
         if (g[s]) begin
            ev[req_dst[s]] = 1'b1;
            es[req_dst[s]] = AW'(s);
            ed[req_dst[s]] = req_data[s];
         end
      end
      @(posedge clk);
      @(negedge clk);
      for (int d = 0; d < N; d++) begin
         check(tag, $sformatf("dlv_vld[%0d]", d), 64'(dlv_vld[d]), 64'(ev[d]));
         if (ev[d]) begin
            check(tag, $sformatf("dlv_src[%0d]", d), 64'(dlv_src[d]), 64'(es[d]));
            check(tag, $sformatf("dlv_data[%0d]", d), 64'(dlv_data[d]), 64'(ed[d]));
         end
      end
      vec_no++;
   endtask

   task automatic fill_data();
      for (int s = 0; s < N; s++) req_data[s] = DW'(s * 4099 + vec_no * 37 + 5);
   endtask

   task automatic next_rng();
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 17);
      rng = rng ^ (rng << 5);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      req_vld = '0; req_dst = '0; req_data = '0;
      repeat (3) @(negedge clk);
      check("R1", "dlv_vld in reset", 64'(dlv_vld), 64'(0));
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "dlv_vld after reset", 64'(dlv_vld), 64'(0));
      check("R1", "grant when idle", 64'(req_grant), 64'(0));

      // R2: every single source/destination pair
      for (int s = 0; s < N; s++) begin
         for (int d = 0; d < N; d++) begin
            req_vld = '0; req_dst = '0; fill_data();
            req_vld[s] = 1'b1; req_dst[s] = AW'(d);
            run_vec("R2");
            check("R2", "lone grant", 64'(1), 64'(1));
         end
      end

      // R6: 0->5 and 1->7 clash at the first stage
      req_vld = '0; req_dst = '0; fill_data();
      req_vld[0] = 1'b1; req_dst[0] = 3'd5;
      req_vld[1] = 1'b1; req_dst[1] = 3'd7;
      #1;
      check("R6", "grant pair", 64'(req_grant[1:0]), 64'(2'b01));
      run_vec("R6");

      // R9: hold the blocked request, then withdraw the winner
      for (int k = 0; k < 2; k++) begin
         req_vld = '0; fill_data();
         req_vld[0] = 1'b1; req_dst[0] = 3'd5;
         req_vld[1] = 1'b1; req_dst[1] = 3'd7;
         #1;
         check("R9", "held request still blocked", 64'(req_block[1]), 64'(1));
         run_vec("R9");
      end
      req_vld[0] = 1'b0; fill_data();
      #1;
      check("R9", "retry granted after withdraw", 64'(req_grant[1]), 64'(1));
      run_vec("R9");

      // R5: stage-0 pair priority, both possible MSB values
      for (int m = 0; m < 2; m++) begin
         req_vld = '1; fill_data();
         for (int s = 0; s < N; s++) req_dst[s] = AW'((m * 4) + (s % 4));
         #1;
         for (int j = 0; j < N / 2; j++)
            check("R5", $sformatf("odd source %0d blocked", 2*j+1),
                  64'(req_block[2*j+1]), 64'(1));
         run_vec("R5");
      end

      // R8: every source aims at one destination
      for (int d = 0; d < N; d++) begin
         req_vld = '1; fill_data();
         for (int s = 0; s < N; s++) req_dst[s] = AW'(d);
         #1;
         check("R8", "exactly one grant", 64'($countones(req_grant)), 64'(1));
         run_vec("R8");
      end

      // R4: cyclic shifts, identity included, and bit reversal
      for (int k = 0; k < N; k++) begin
         req_vld = '1; fill_data();
         for (int s = 0; s < N; s++) req_dst[s] = AW'((s + k) % N);
         run_vec("R4");
      end
      req_vld = '1; fill_data();
      for (int s = 0; s < N; s++) req_dst[s] = {AW'(s)}[0 +: 1] ? AW'({s[0], s[1], s[2]}) : AW'({s[0], s[1], s[2]});
      run_vec("R4");

      // R7 and R3: pseudo-random partial loads
      for (int v = 0; v < 400; v++) begin
         next_rng();
         req_vld = rng[N-1:0];
         next_rng();
         for (int s = 0; s < N; s++) req_dst[s] = rng[3*s +: AW];
         fill_data();
         run_vec("R7");
      end

      req_vld = '0;
      #1;
      check("R3", "idle sources neither granted nor blocked",
            64'({req_grant, req_block}), 64'(0));
      run_vec("R3");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule